// File: doc/BRIEF.md
# Programmable Down-Counter With Square-Wave and One-Shot Output

This block is a down-counter with a parameterized width, 16 bits by default. An enable input paces it: the counter moves one step only on cycles where that input is high. The block that instantiates it picks the source of those enable pulses. The top module sees a preload value, a mode select, a start strobe and a stop strobe. It drives a level output that can feed a pin, and a sticky terminal-count flag.

The block has two modes:

- **Square-wave mode.** The counter reloads from the preload each time it expires, and the output toggles on every expiry. A full output period therefore lasts twice the preload, counted in enable pulses.
- **One-shot mode.** The output rests high and drops low on the first expiry. It stays low while the counter keeps stepping down and wrapping around, and returns high only on a stop strobe. No mask or interrupt enable gates the output, so it can drive an open-drain pin stage directly.

Top module: `ct_modetimer`

## Requirements
- R1: After reset the output is high and the terminal flag is low, and enable pulses have no effect until a start strobe arrives.
- R2: A start strobe loads the preload value P (with P of 2 or more) and starts counting. The terminal flag is still low after P-1 enable pulses and is high after the P-th.
- R3: The count changes only on cycles where the enable input is high. Cycles without an enable pulse do not advance the expiry.
- R4: In square-wave mode (mode input = 1), a start strobe sets the output high. The output then toggles after every P enable pulses, because the counter reloads P at each expiry.
- R5: In one-shot mode (mode input = 0), the output falls at the first expiry and stays low through any number of further enable pulses, including counter wraparound, until a stop strobe.
- R6: A stop strobe halts counting, sets the output high and clears the terminal flag. Later enable pulses do not set the flag again.
- R7: A preload of 0 or 1 acts as a period of one enable pulse in both modes, and the counter never stalls.
- R8: The terminal flag is set at the first expiry in either mode and stays set until a stop strobe.
- R9: When start and stop arrive in the same cycle, stop wins: the block ends up idle with the output high and the flag clear.
- R10: A start strobe while the block is running restarts the countdown from the preload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preload | input | 16 | Reload value, sampled on start and on each square-wave expiry |
| mode | input | 1 | 1 = square wave, 0 = one-shot |
| start | input | 1 | Start strobe (load and run) |
| stop | input | 1 | Stop strobe (halt, output high, flag clear) |
| tick | input | 1 | Count enable, one step per high cycle |
| out_level | output | 1 | Mode output level |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The assertions check the following on every cycle:

- The count holds still on cycles without an enable pulse or a load.
- A load never leaves the counter at zero.
- A stop always restores a high output and a clear flag.
- The flag stays set until a stop arrives.
- A one-shot low output stays low.
- Every square-wave expiry flips the output.

Whether expiry happens after exactly the preload number of pulses, whether start and stop resolve in the right order, and whether a restart reloads the countdown can only be shown by the bench. It does this with directed sequences and with a cycle-by-cycle reference model under random stimulus.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic {
    CT_ONESHOT = 1'b0,
    CT_SQUARE  = 1'b1
  } ct_mode_e;
endpackage

// File: rtl/ct_cmd.sv
// Command resolution: stop dominates start; tracks the running state.
module ct_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic load,
  output logic halt,
  output logic run
);
  assign halt = stop;
  assign load = start & ~stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 1'b0;
    else if (halt) run <= 1'b0;
    else if (load) run <= 1'b1;
  end

  // R9: a simultaneous start and stop leaves the block idle
  a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stop) |=> !run);
endmodule

// File: rtl/ct_down.sv
// Down-counter register and expiry event.
module ct_down #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic             run,
  input  logic             tick,
  input  ct_pkg::ct_mode_e mode,
  input  logic [W-1:0]     preload,
  output logic [W-1:0]     count,
  output logic             term
);
  localparam logic [W-1:0] ONE = W'(1);

  // Preloads of 0 and 1 both act as the one-pulse minimum period.
  function automatic logic [W-1:0] eff_load(input logic [W-1:0] p);
    return (p < W'(2)) ? ONE : p;
  endfunction

  // Value after one enabled step. At expiry, square-wave mode reloads
  // and one-shot mode falls to zero (and later wraps).
  function automatic logic [W-1:0] step(input logic [W-1:0] c,
                                        input logic [W-1:0] rl,
                                        input logic         sq);
    if (c == ONE) return sq ? rl : '0;
    return c - ONE;
  endfunction

  logic advance;
  assign advance = run & tick & ~load & ~halt;
  assign term    = advance & (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= eff_load(preload);
    else if (advance) count <= step(count, eff_load(preload), mode == ct_pkg::CT_SQUARE);
  end

  // R3: no enable pulse and no load -> count unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  // R7: a load never leaves a zero count
  a_r7_nonzero_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count != '0));
endmodule

// File: rtl/ct_wave.sv
// Output level and sticky terminal flag.
module ct_wave (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic             term,
  input  ct_pkg::ct_mode_e mode,
  output logic             out_level,
  output logic             tc_flag
);
  logic sq;
  assign sq = (mode == ct_pkg::CT_SQUARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_level <= 1'b1;
      tc_flag   <= 1'b0;
    end else if (halt) begin
      out_level <= 1'b1;
      tc_flag   <= 1'b0;
    end else if (load) begin
      if (sq) out_level <= 1'b1;
    end else if (term) begin
      tc_flag   <= 1'b1;
      out_level <= sq ? ~out_level : 1'b0;
    end
  end

  // R6: stop restores a high output and a clear flag
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (out_level && !tc_flag));
  // R8: the flag is sticky until stop
  a_r8_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_flag && !halt) |=> tc_flag);
  // R5: a one-shot low output stays low until stop
  a_r5_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq && !out_level && !halt) |=> !out_level);
  // R4: every square-wave expiry flips the output
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (term && sq) |=> (out_level != $past(out_level)));
endmodule

// File: rtl/ct_modetimer.sv
module ct_modetimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] preload,
  input  logic         mode,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  output logic         out_level,
  output logic         tc_flag
);
  import ct_pkg::*;

  ct_mode_e     mode_e;
  logic         load, halt, run, term;
  logic [W-1:0] count;

  assign mode_e = ct_mode_e'(mode);

  ct_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .load(load), .halt(halt), .run(run)
  );

  ct_down #(.W(W)) u_down (
    .clk(clk), .rst_n(rst_n), .load(load), .halt(halt), .run(run),
    .tick(tick), .mode(mode_e), .preload(preload),
    .count(count), .term(term)
  );

  ct_wave u_wave (
    .clk(clk), .rst_n(rst_n), .load(load), .halt(halt), .term(term),
    .mode(mode_e), .out_level(out_level), .tc_flag(tc_flag)
  );

  // R1: nothing expires while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !term);
endmodule

// File: tb/ct_modetimer_bench.sv
module ct_modetimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] preload = '0;
  logic        mode = 1'b0, start = 1'b0, stop = 1'b0, tick = 1'b0;
  logic        out_level, tc_flag;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ct_modetimer u_ct_modetimer (
    .clk(clk), .rst_n(rst_n), .preload(preload), .mode(mode),
    .start(start), .stop(stop), .tick(tick),
    .out_level(out_level), .tc_flag(tc_flag)
  );

  function automatic int period_of(input logic [15:0] p);
    return (p <= 16'd1) ? 1 : int'(p);
  endfunction

  // Output level after k enable pulses in square-wave mode.
  function automatic logic sq_level(input int k, input int per);
    return ((k / per) % 2) == 0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs; sample one step after the edge.
  task automatic cyc(input logic s, input logic p, input logic t);
    start = s; stop = p; tick = t;
    @(posedge clk); #1;
    start = 0; stop = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1);
  endtask

  // reference model state for the random phase
  logic        m_run, m_out, m_tc;
  logic [15:0] m_cnt;

  task automatic model_step(input logic s, input logic p, input logic t);
    if (p) begin
      m_run = 0; m_out = 1; m_tc = 0;
    end else if (s) begin
      m_run = 1; m_cnt = 16'(period_of(preload));
      if (mode) m_out = 1;
    end else if (m_run && t) begin
      if (m_cnt == 16'd1) begin
        m_tc = 1;
        if (mode) begin m_out = ~m_out; m_cnt = 16'(period_of(preload)); end
        else begin m_out = 0; m_cnt = 16'd0; end
      end else m_cnt = m_cnt - 16'd1;
    end
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 out", out_level, 1); chk("R1 tc", tc_flag, 0);
    ticks(8);
    chk("R1 idle tc", tc_flag, 0); chk("R1 idle out", out_level, 1);

    // one-shot, P=5
    mode = 0; preload = 16'd5;
    cyc(1, 0, 0);
    ticks(4);
    chk("R2 before", tc_flag, 0); chk("R5 high", out_level, 1);
    ticks(1);
    chk("R2 expiry", tc_flag, 1); chk("R5 fall", out_level, 0);
    ticks(20);
    chk("R5 stays low", out_level, 0); chk("R8 sticky", tc_flag, 1);
    cyc(0, 1, 0);
    chk("R6 out", out_level, 1); chk("R6 tc", tc_flag, 0);
    ticks(10);
    chk("R6 halted", tc_flag, 0); chk("R6 out held", out_level, 1);

    // enable gating, P=3
    preload = 16'd3;
    cyc(1, 0, 0);
    repeat (10) cyc(0, 0, 0);
    ticks(2);
    chk("R3 gated", tc_flag, 0);
    repeat (4) cyc(0, 0, 0);
    ticks(1);
    chk("R3 expiry", tc_flag, 1);
    cyc(0, 1, 0);

    // square wave, P=4
    mode = 1; preload = 16'd4;
    cyc(1, 0, 0);
    chk("R4 start high", out_level, 1);
    for (int k = 1; k <= 16; k++) begin
      ticks(1);
      chk("R4 wave", out_level, sq_level(k, 4));
      chk("R8 tc", tc_flag, k >= 4);
    end
    cyc(0, 1, 0);

    // minimum period for preload 0 and 1
    for (int pv = 0; pv < 2; pv++) begin
      preload = 16'(pv); mode = 1;
      cyc(1, 0, 0);
      for (int k = 1; k <= 6; k++) begin
        ticks(1);
        chk("R7 square min", out_level, sq_level(k, 1));
      end
      cyc(0, 1, 0);
      mode = 0;
      cyc(1, 0, 0);
      ticks(1);
      chk("R7 oneshot min", tc_flag, 1); chk("R7 oneshot low", out_level, 0);
      cyc(0, 1, 0);
    end

    // start and stop together while running
    mode = 1; preload = 16'd2;
    cyc(1, 0, 0);
    ticks(2);
    chk("R9 setup", out_level, 0);
    cyc(1, 1, 0);
    chk("R9 out", out_level, 1); chk("R9 tc", tc_flag, 0);
    ticks(5);
    chk("R9 idle", tc_flag, 0); chk("R9 idle out", out_level, 1);

    // restart while running, one-shot P=6
    mode = 0; preload = 16'd6;
    cyc(1, 0, 0);
    ticks(4);
    cyc(1, 0, 1);
    ticks(5);
    chk("R10 restarted", tc_flag, 0);
    ticks(1);
    chk("R10 expiry", tc_flag, 1);
    cyc(0, 1, 0);

    // random phase against the reference model
    void'($urandom(32'h1234_5678));
    m_run = 0; m_out = 1; m_tc = 0; m_cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      logic s, p, t;
      if (($urandom % 200) == 0) mode = $urandom % 2;
      if (($urandom % 50) == 0) preload = 16'($urandom % 7);
      s = ($urandom % 60) == 0;
      p = ($urandom % 90) == 0;
      t = ($urandom % 2) == 0;
      model_step(s, p, t);
      cyc(s, p, t);
      chk("R4/R5 random out", out_level, m_out);
      chk("R8 random tc", tc_flag, m_tc);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule